// File: doc/BRIEF.md
# Vertical Border Decision Timer

This block tracks the raster position of a video timing generator and produces the vertical display-enable window for each frame. It counts clock cycles within a scan line and scan lines within a frame. Both counts restart on a frame-start strobe. The CPU sets a one-bit refresh-rate register through a write strobe, where a set bit selects 60 Hz.

The block looks at that register only at one fixed cycle of the line, and only on a few lines that carry a decision. On the top decision line, a 60 Hz level at that cycle starts the display window early, so the top border is removed. On the bottom decision line, a 60 Hz level at that cycle keeps the window open until the next frame start, so the bottom border is removed. Where no such decision is taken, the window opens and closes on the normal 50 Hz lines.

The block has no edge detection. A value that the register holds before the sampling cycle, or takes after it, has no effect. A wake-alignment input moves the sampling cycle two clocks later. That input is captured only while reset is held.

Top module: `vborder_top`

## Requirements
- R1: The cycle counter runs 0..511 and wraps to 0, and each wrap adds one to the line counter. A `vsync_start` strobe zeroes both counters at the next clock and clears `vde`. After reset both counters are 0 and `vde` is 0.
- R2: When `freq_we` is high at a clock edge, `freq_wdata` (1 = 60 Hz, 0 = 50 Hz) enters the rate register at that edge. The sampler therefore first sees it on the following edge, so a write strobed in the sampling cycle itself is not seen there.
- R3: The sampling cycle is 502 when `wake_alt` was low during reset and 504 when it was high. Changes of `wake_alt` while reset is low have no effect.
- R4: On line 33, a 60 Hz register value at the sampling cycle raises `vde` from the next clock.
- R5: If the top border was not removed, `vde` rises at the clock after the sampling cycle of line 63.
- R6: On line 199, a 60 Hz register value at the sampling cycle keeps `vde` high until the next `vsync_start`.
- R7: If the bottom border was not removed, `vde` falls at the clock after the sampling cycle of line 263.
- R8: Only the level matters. A switch to 60 Hz and back that ends before the sampling cycle has no effect. A return to 50 Hz strobed in or after the sampling cycle does not undo a removal.
- R9: `vde` changes only in the cycle after a sampling-cycle edge or after a `vsync_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/bus clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_start | input | 1 | Frame-start strobe |
| wake_alt | input | 1 | Alternate wake alignment, captured during reset |
| freq_we | input | 1 | Rate register write strobe |
| freq_wdata | input | 1 | Rate value, 1 = 60 Hz |
| vde | output | 1 | Vertical display enable |
| line_cnt | output | LINE_W (9) | Current line in the frame |
| cyc_cnt | output | CYC_W (9) | Current cycle in the line |

## Verification
A wrong sampling cycle or a stale rate register shows at the ports as a `vde` edge that is missing, early or late. That edge appears one clock after the decision cycle of the line concerned, and the per-clock model comparison catches it there. A corrupted window state may stay hidden until the next decision line or frame start. A miscounted position, by contrast, shows in `cyc_cnt` or `line_cnt` on the very next clock. Directed frames place rate writes just before, inside and just after the sampling cycle under both wake alignments. This exposes off-by-one errors in both the write path and the sampling compare.

// File: rtl/vborder_pkg.sv
package vborder_pkg;

   typedef enum logic [1:0] {
      VS_PRE    = 2'd0,
      VS_ACTIVE = 2'd1,
      VS_OPEN   = 2'd2,
      VS_DONE   = 2'd3
   } vstate_t;

   function automatic logic vstate_visible(input vstate_t s);
      return (s == VS_ACTIVE) || (s == VS_OPEN);
   endfunction

endpackage

// File: rtl/vb_freq_reg.sv
module vb_freq_reg (
   input  logic clk,
   input  logic rst,
   input  logic wr_en,
   input  logic wr_data,
   output logic freq_60
);
   always_ff @(posedge clk) begin
      if (rst)        freq_60 <= 1'b0;
      else if (wr_en) freq_60 <= wr_data;
   end
endmodule

// File: rtl/vb_position.sv
module vb_position #(
   parameter int CYC_W       = 9,
   parameter int LINE_W      = 9,
   parameter int LINE_CYCLES = 512
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vsync,
   output logic [CYC_W-1:0]  cyc,
   output logic [LINE_W-1:0] line
);
   localparam logic [CYC_W-1:0]  CYC_LAST = CYC_W'(LINE_CYCLES - 1);
   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   logic wrap;
   assign wrap = (cyc == CYC_LAST);

   always_ff @(posedge clk) begin
      if (rst || vsync) begin
         cyc  <= '0;
         line <= '0;
      end else if (wrap) begin
         cyc <= '0;
         if (line != LINE_MAX) line <= line + 1'b1;
      end else begin
         cyc <= cyc + 1'b1;
      end
   end
endmodule

// File: rtl/vb_border_fsm.sv
module vb_border_fsm
   import vborder_pkg::*;
#(
   parameter int LINE_W        = 9,
   parameter int TOP_DEC_LINE  = 33,
   parameter int TOP_NORM_LINE = 63,
   parameter int BOT_DEC_LINE  = 199,
   parameter int BOT_NORM_LINE = 263
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vsync,
   input  logic              at_sample,
   input  logic [LINE_W-1:0] line,
   input  logic              freq_60,
   output logic              vde
);
   localparam logic [LINE_W-1:0] L_TOP_DEC  = LINE_W'(TOP_DEC_LINE);
   localparam logic [LINE_W-1:0] L_TOP_NORM = LINE_W'(TOP_NORM_LINE);
   localparam logic [LINE_W-1:0] L_BOT_DEC  = LINE_W'(BOT_DEC_LINE);
   localparam logic [LINE_W-1:0] L_BOT_NORM = LINE_W'(BOT_NORM_LINE);

   vstate_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (at_sample) begin
         unique case (st_q)
            VS_PRE: begin
               if ((line == L_TOP_DEC) && freq_60) st_d = VS_ACTIVE;
               else if (line == L_TOP_NORM)        st_d = VS_ACTIVE;
            end
            VS_ACTIVE: begin
               if ((line == L_BOT_DEC) && freq_60) st_d = VS_OPEN;
               else if (line == L_BOT_NORM)        st_d = VS_DONE;
            end
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || vsync) st_q <= VS_PRE;
      else              st_q <= st_d;
   end

   assign vde = vstate_visible(st_q);
endmodule

// File: rtl/vborder_top.sv
module vborder_top #(
   parameter int CYC_W         = 9,
   parameter int LINE_W        = 9,
   parameter int LINE_CYCLES   = 512,
   parameter int SAMPLE_STD    = 502,
   parameter int SAMPLE_ALT    = 504,
   parameter bit ALT_SUPPORT   = 1'b1,
   parameter int TOP_DEC_LINE  = 33,
   parameter int TOP_NORM_LINE = 63,
   parameter int BOT_DEC_LINE  = 199,
   parameter int BOT_NORM_LINE = 263
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vsync_start,
   input  logic              wake_alt,
   input  logic              freq_we,
   input  logic              freq_wdata,
   output logic              vde,
   output logic [LINE_W-1:0] line_cnt,
   output logic [CYC_W-1:0]  cyc_cnt
);
   localparam logic [CYC_W-1:0] S_STD = CYC_W'(SAMPLE_STD);
   localparam logic [CYC_W-1:0] S_ALT = CYC_W'(SAMPLE_ALT);

   if (LINE_CYCLES > (1 << CYC_W)) begin : g_bad_cyc
      $error("LINE_CYCLES does not fit CYC_W");
   end
   if ((SAMPLE_STD >= LINE_CYCLES) || (SAMPLE_ALT >= LINE_CYCLES)) begin : g_bad_samp
      $error("sampling cycle outside line");
   end
   if ((TOP_DEC_LINE >= TOP_NORM_LINE) || (TOP_NORM_LINE >= BOT_DEC_LINE) ||
       (BOT_DEC_LINE >= BOT_NORM_LINE) || (BOT_NORM_LINE >= (1 << LINE_W))) begin : g_bad_lines
      $error("decision lines out of order or too wide");
   end

   logic             alt_q;
   logic [CYC_W-1:0] samp_cyc;
   logic             at_sample;
   logic             freq_60;

   if (ALT_SUPPORT) begin : g_alt
      always_ff @(posedge clk) begin
         if (rst) alt_q <= wake_alt;
      end
   end else begin : g_std_only
      assign alt_q = 1'b0;
      logic unused_wake;
      assign unused_wake = wake_alt;
   end

   assign samp_cyc  = alt_q ? S_ALT : S_STD;
   assign at_sample = (cyc_cnt == samp_cyc);

   vb_freq_reg i_freq (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (freq_we),
      .wr_data (freq_wdata),
      .freq_60 (freq_60)
   );

   vb_position #(
      .CYC_W       (CYC_W),
      .LINE_W      (LINE_W),
      .LINE_CYCLES (LINE_CYCLES)
   ) i_pos (
      .clk   (clk),
      .rst   (rst),
      .vsync (vsync_start),
      .cyc   (cyc_cnt),
      .line  (line_cnt)
   );

   vb_border_fsm #(
      .LINE_W        (LINE_W),
      .TOP_DEC_LINE  (TOP_DEC_LINE),
      .TOP_NORM_LINE (TOP_NORM_LINE),
      .BOT_DEC_LINE  (BOT_DEC_LINE),
      .BOT_NORM_LINE (BOT_NORM_LINE)
   ) i_fsm (
      .clk       (clk),
      .rst       (rst),
      .vsync     (vsync_start),
      .at_sample (at_sample),
      .line      (line_cnt),
      .freq_60   (freq_60),
      .vde       (vde)
   );
endmodule

// File: rtl/vborder_chk.sv
module vborder_chk #(
   parameter int CYC_W        = 9,
   parameter int LINE_W       = 9,
   parameter int LINE_CYCLES  = 512,
   parameter int TOP_DEC_LINE = 33,
   parameter int BOT_DEC_LINE = 199
) (
   input logic              clk,
   input logic              rst,
   input logic              vsync,
   input logic              wr_en,
   input logic              wr_data,
   input logic              freq_60,
   input logic              at_sample,
   input logic [CYC_W-1:0]  samp_cyc,
   input logic              vde,
   input logic [LINE_W-1:0] line_cnt,
   input logic [CYC_W-1:0]  cyc_cnt
);
   localparam logic [CYC_W-1:0]  C_LAST = CYC_W'(LINE_CYCLES - 1);
   localparam logic [LINE_W-1:0] L_MAX  = {LINE_W{1'b1}};
   localparam logic [LINE_W-1:0] L_TOP  = LINE_W'(TOP_DEC_LINE);
   localparam logic [LINE_W-1:0] L_BOT  = LINE_W'(BOT_DEC_LINE);

   p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      (cyc_cnt == C_LAST && !vsync && line_cnt != L_MAX)
      |=> (cyc_cnt == '0 && line_cnt == $past(line_cnt) + 1'b1));

   p_vsync_clear_r1: assert property (@(posedge clk) disable iff (rst)
      vsync |=> (cyc_cnt == '0 && line_cnt == '0 && !vde));

   p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (freq_60 == $past(wr_data)));

   p_samp_fixed_r3: assert property (@(posedge clk) disable iff (rst)
      $stable(samp_cyc));

   p_top_open_r4: assert property (@(posedge clk) disable iff (rst)
      (at_sample && line_cnt == L_TOP && freq_60 && !vsync && !vde) |=> vde);

   p_bot_open_r6: assert property (@(posedge clk) disable iff (rst)
      (at_sample && line_cnt == L_BOT && freq_60 && !vsync && vde) |=> vde);

   p_vde_timing_r9: assert property (@(posedge clk) disable iff (rst)
      !$stable(vde) |-> ($past(at_sample) || $past(vsync)));
endmodule

bind vborder_top vborder_chk #(
   .CYC_W        (CYC_W),
   .LINE_W       (LINE_W),
   .LINE_CYCLES  (LINE_CYCLES),
   .TOP_DEC_LINE (TOP_DEC_LINE),
   .BOT_DEC_LINE (BOT_DEC_LINE)
) i_vborder_chk (
   .clk       (clk),
   .rst       (rst),
   .vsync     (vsync_start),
   .wr_en     (freq_we),
   .wr_data   (freq_wdata),
   .freq_60   (freq_60),
   .at_sample (at_sample),
   .samp_cyc  (samp_cyc),
   .vde       (vde),
   .line_cnt  (line_cnt),
   .cyc_cnt   (cyc_cnt)
);

// File: tb/test_vborder_top.sv
module test_vborder_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 9;
   localparam int LW = 9;
   localparam int T_DEC = 3, T_NORM = 5, B_DEC = 9, B_NORM = 12, FRAME_END = 14;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic vsync_start = 1'b0;
   logic wake_alt = 1'b0;
   logic freq_we = 1'b0;
   logic freq_wdata = 1'b0;
   logic vde;
   logic [LW-1:0] line_cnt;
   logic [CW-1:0] cyc_cnt;

   int checks = 0;
   int errors = 0;
   int ticks = 0;

   int m_cyc = 0, m_line = 0, m_st = 0, m_freq = 0, m_samp = 502;

   always #(CLK_PERIOD/2) clk = ~clk;

   vborder_top #(
      .CYC_W(CW), .LINE_W(LW),
      .TOP_DEC_LINE(T_DEC), .TOP_NORM_LINE(T_NORM),
      .BOT_DEC_LINE(B_DEC), .BOT_NORM_LINE(B_NORM)
   ) i_vborder_top (
      .clk(clk), .rst(rst), .vsync_start(vsync_start), .wake_alt(wake_alt),
      .freq_we(freq_we), .freq_wdata(freq_wdata),
      .vde(vde), .line_cnt(line_cnt), .cyc_cnt(cyc_cnt)
   );

   // behavioural reference: 0 waiting, 1 shown, 2 held open, 3 closed
   always @(posedge clk) begin
      if (rst) begin
         m_cyc = 0; m_line = 0; m_st = 0; m_freq = 0;
         m_samp = wake_alt ? 504 : 502;
      end else begin
         if (vsync_start) begin
            m_cyc = 0; m_line = 0; m_st = 0;
         end else begin
            if (m_cyc == m_samp) begin
               if (m_st == 0 && ((m_line == T_DEC && m_freq == 1) || m_line == T_NORM)) m_st = 1;
               else if (m_st == 1 && m_line == B_DEC && m_freq == 1) m_st = 2;
               else if (m_st == 1 && m_line == B_NORM) m_st = 3;
            end
            if (m_cyc == 511) begin
               m_cyc = 0;
               if (m_line < 511) m_line = m_line + 1;
            end else m_cyc = m_cyc + 1;
         end
         if (freq_we) m_freq = int'(freq_wdata);
      end
   end

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at line %0d cyc %0d: actual=%0d expected=%0d", req, m_line, m_cyc, act, exp);
      end
   endtask

   // per-clock comparison with the reference (R1 counters, R9 window edges)
   always @(negedge clk) begin
      ticks++;
      if (ticks > WATCHDOG) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", ticks, WATCHDOG);
         report();
      end
      if (!rst) begin
         chk("R1 cyc_cnt", int'(cyc_cnt), m_cyc);
         chk("R1 line_cnt", int'(line_cnt), m_line);
         chk("R9 vde track", int'(vde), (m_st == 1 || m_st == 2) ? 1 : 0);
      end
   end

   task automatic wait_pos(input int l, input int c);
      while (!(m_line == l && m_cyc == c)) @(negedge clk);
   endtask

   task automatic wr_at(input int l, input int c, input logic v);
      wait_pos(l, c);
      freq_we = 1'b1; freq_wdata = v;
      @(negedge clk);
      freq_we = 1'b0;
   endtask

   task automatic new_frame;
      wait_pos(FRAME_END, 0);
      vsync_start = 1'b1;
      @(negedge clk);
      vsync_start = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset(input logic alt);
      @(negedge clk);
      rst = 1'b1; wake_alt = alt;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      do_reset(1'b0);
      chk("R1 reset vde", int'(vde), 0);
      chk("R1 reset line", int'(line_cnt), 0);
      chk("R1 reset cyc", int'(cyc_cnt), 1);

      // frame 1: top removed, bottom switch returns too early
      new_frame();
      wr_at(T_DEC, 501, 1'b1);
      wr_at(T_DEC, 504, 1'b0);
      wait_pos(T_DEC + 1, 0);
      chk("R4 top removed", int'(vde), 1);
      wr_at(B_DEC, 495, 1'b1);
      wr_at(B_DEC, 500, 1'b0);
      wait_pos(B_NORM, 502);
      chk("R7 still shown at sample", int'(vde), 1);
      @(negedge clk);
      chk("R7 closes after sample", int'(vde), 0);

      // frame 2: switch done before sample has no effect; bottom held open
      new_frame();
      chk("R1 vsync clears line", int'(line_cnt), 0);
      wr_at(T_DEC, 100, 1'b1);
      wr_at(T_DEC, 200, 1'b0);
      wait_pos(T_DEC + 1, 0);
      chk("R8 early pulse ignored", int'(vde), 0);
      wait_pos(T_NORM, 502);
      chk("R5 not yet shown", int'(vde), 0);
      @(negedge clk);
      chk("R5 shown after normal sample", int'(vde), 1);
      wr_at(B_DEC, 500, 1'b1);
      wr_at(B_DEC, 502, 1'b0);
      wait_pos(B_NORM + 1, 0);
      chk("R6 bottom held open", int'(vde), 1);
      chk("R8 late return kept open", int'(vde), 1);
      wait_pos(FRAME_END, 0);
      chk("R6 open until vsync", int'(vde), 1);
      vsync_start = 1'b1;
      @(negedge clk);
      vsync_start = 1'b0;
      chk("R1 vsync clears vde", int'(vde), 0);
      chk("R1 vsync clears cyc", int'(cyc_cnt), 0);

      // frame 3: write strobed in the sample cycle is not seen
      wr_at(T_DEC, 502, 1'b1);
      wr_at(T_DEC, 510, 1'b0);
      wait_pos(T_DEC + 1, 0);
      chk("R2 write in sample cycle unseen", int'(vde), 0);

      // frame 4: alternate alignment captured at reset, then input dropped
      do_reset(1'b1);
      wake_alt = 1'b0;
      new_frame();
      wr_at(T_DEC, 503, 1'b1);
      wr_at(T_DEC, 504, 1'b0);
      wait_pos(T_DEC + 1, 0);
      chk("R3 alt sample at 504", int'(vde), 1);
      wr_at(B_DEC, 501, 1'b1);
      wr_at(B_DEC, 503, 1'b0);
      wait_pos(B_NORM + 1, 0);
      chk("R3 alt ignores 502", int'(vde), 0);

      report();
   end
endmodule